// File: doc/BRIEF.md
# Complementary PWM Channel with Shadowed Period and Pulse Width

This block is one pulse-width-modulation channel for motor drives. A counter runs against a period value and a pulse-width value. Each cycle, the channel compares the count with both values and drives a complementary pair of outputs. Output A is the primary output. Output B is its complement, and B's rise can be delayed by a programmable dead time so that the two switches of a half bridge are never on together.

The period and pulse-width values are each held twice. Software writes a staging copy. The comparators use a working copy. While the channel is stopped, the working copy follows the staging copy. While the channel runs, the working copy is refreshed only at a period boundary, and a hold bit can block that refresh. To change period and pulse width together, software sets the hold bit, writes both values, then clears the bit. Both values then take effect at the same boundary.

The counter has two modes. In edge mode it counts up and wraps to zero. In centre mode it counts up and then back down. All register traffic uses a single write port and a single registered read port.

Top module: `mcpwm_chan`

## Requirements
- R1: After a synchronous reset, the following hold. The counter is 0. Both period copies are all ones. Both pulse-width copies are 0. The control word is 0. Both outputs are low. The read data is 0.
- R2: In edge mode while running, the counter steps up by one each clock. In the clock after the counter is at or above the working period, the counter is 0. A period therefore lasts period+1 clocks.
- R3: In centre mode while running, the counter counts up. When it is at or above the working period, it turns and counts down. In the clock after it is 0 while counting down, it is 1 and counting up. A period therefore lasts 2×period clocks.
- R4: While the run bit is clear, three things hold. The counter is held at 0. Both outputs sit at their passive level (0 XOR their polarity bit). Each working copy equals its staging copy, and a write lands in both copies at the same edge.
- R5: While running, A is active when the counter is below the working pulse width. In edge mode, a cycle in which the counter is at or above the working period makes A passive, even when the pulse width exceeds the period. Outputs are registered, so each output shows the previous cycle's comparison.
- R6: With dead time disabled, B is active exactly when the channel runs and A is passive. This includes the edge-mode period hit, where A turns passive and B turns active on the same clock.
- R7: With dead time enabled, each time B's demand rises, a down counter loads the 10-bit dead-time value D, and B stays passive until that counter reaches 0. B therefore turns active D clocks after A turns passive. If A turns active again first, B stays passive.
- R8: While running with the hold bit clear, both working copies load from their staging copies at a boundary. In edge mode, the boundary is the period hit. In centre mode, it is the clock where the counter is 0 while counting down.
- R9: While running with the hold bit set, the working copies do not change. Clearing the hold bit lets both staged values take effect at the next boundary. Stopping the channel loads them at once.
- R10: Reads are registered, with one clock of latency. The read selects are 0 for the working period, 1 for the working pulse width, 2 for the control word and 3 for the counter. Select 3 is read-only for writes, and a write to it is ignored.
- R11: Control bit 4 inverts A and bit 5 inverts B at the output pins, and each takes effect in the clock after the control write.
- R12: The control word layout is as follows. Bit 0 is run. Bit 1 selects centre mode. Bit 2 enables dead time. Bit 3 is hold. Bits 25:16 hold the dead time. Other bits read back as 0. A control write acts from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 period, 1 pulse width, 2 control |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Read select, as in R10 |
| rd_data | output | CNT_W | Registered read data |
| out_a | output | 1 | Primary PWM output, polarity applied |
| out_b | output | 1 | Complementary PWM output with dead time, polarity applied |

## Verification
The properties assume only that reset is applied before traffic. They also rely on the rule that a write made while running cannot reach a working copy, so the hold property needs no constraint on write timing. Mode, polarity and dead-time changes are made while the channel runs, including a switch from centre back to edge with the direction flag left set. The stimulus keeps period values small, so that many wraps, turnarounds and boundary loads occur in a short run. It also includes a pulse width above the period and a dead time longer than B's demand window, so that the cancellation path is exercised.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
  // Control word field positions (R12)
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned CEN_BIT  = 1;
  localparam int unsigned DTE_BIT  = 2;
  localparam int unsigned HOLD_BIT = 3;
  localparam int unsigned POLA_BIT = 4;
  localparam int unsigned POLB_BIT = 5;
  localparam int unsigned DT_LSB   = 16;

  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_WIDTH  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_COUNT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic run;
    logic center;
    logic dt_en;
    logic hold;
    logic pol_a;
    logic pol_b;
  } ctl_flags_t;
endpackage

// File: rtl/mcpwm_regs.sv
module mcpwm_regs
  import mcpwm_pkg::*;
#(
  parameter int unsigned CW  = 32,
  parameter int unsigned DTW = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CW-1:0]    wr_data,
  input  logic [1:0]       rd_sel,
  input  logic             bound,
  input  logic [CW-1:0]    tc,
  output logic [CW-1:0]    per_op,
  output logic [CW-1:0]    wid_op,
  output ctl_flags_t       flags,
  output logic [DTW-1:0]   dt_val,
  output logic [CW-1:0]    rd_data
);
  logic [CW-1:0] per_st, wid_st, ctl_word;
  logic          reload;

  // Stopped: working copies follow staging; running: only at unheld boundary
  assign reload = !flags.run || (bound && !flags.hold);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_st <= '1;
      per_op <= '1;
      wid_st <= '0;
      wid_op <= '0;
      flags  <= '0;
      dt_val <= '0;
    end else begin
      if (reload) begin
        per_op <= per_st;
        wid_op <= wid_st;
      end
      if (wr_en) begin
        case (reg_sel_e'(wr_sel))
          SEL_PERIOD: begin
            per_st <= wr_data;
            if (!flags.run) per_op <= wr_data;
          end
          SEL_WIDTH: begin
            wid_st <= wr_data;
            if (!flags.run) wid_op <= wr_data;
          end
          SEL_CTRL: begin
            flags.run    <= wr_data[RUN_BIT];
            flags.center <= wr_data[CEN_BIT];
            flags.dt_en  <= wr_data[DTE_BIT];
            flags.hold   <= wr_data[HOLD_BIT];
            flags.pol_a  <= wr_data[POLA_BIT];
            flags.pol_b  <= wr_data[POLB_BIT];
            dt_val       <= wr_data[DT_LSB +: DTW];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    ctl_word                 = '0;
    ctl_word[RUN_BIT]        = flags.run;
    ctl_word[CEN_BIT]        = flags.center;
    ctl_word[DTE_BIT]        = flags.dt_en;
    ctl_word[HOLD_BIT]       = flags.hold;
    ctl_word[POLA_BIT]       = flags.pol_a;
    ctl_word[POLB_BIT]       = flags.pol_b;
    ctl_word[DT_LSB +: DTW]  = dt_val;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (reg_sel_e'(rd_sel))
        SEL_PERIOD: rd_data <= per_op;
        SEL_WIDTH:  rd_data <= wid_op;
        SEL_CTRL:   rd_data <= ctl_word;
        SEL_COUNT:  rd_data <= tc;
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mcpwm_timer.sv
module mcpwm_timer #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          center,
  input  logic [CW-1:0] per_op,
  output logic [CW-1:0] tc,
  output logic          cnt_down,
  output logic          edge_hit,
  output logic          bound
);
  logic at_top;

  assign at_top   = (tc >= per_op);
  assign edge_hit = run && !center && at_top;
  assign bound    = edge_hit || (run && center && cnt_down && (tc == '0));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      tc       <= '0;
      cnt_down <= 1'b0;
    end else if (!center) begin
      tc <= at_top ? '0 : tc + CW'(1);
    end else if (!cnt_down) begin
      if (at_top) begin
        cnt_down <= 1'b1;
        tc       <= (tc == '0) ? '0 : tc - CW'(1);
      end else begin
        tc <= tc + CW'(1);
      end
    end else if (tc == '0) begin
      cnt_down <= 1'b0;
      tc       <= CW'(1);
    end else begin
      tc <= tc - CW'(1);
    end
  end
endmodule

// File: rtl/mcpwm_outgen.sv
module mcpwm_outgen #(
  parameter int unsigned CW  = 32,
  parameter int unsigned DTW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           dt_en,
  input  logic           pol_a,
  input  logic           pol_b,
  input  logic           edge_hit,
  input  logic [CW-1:0]  tc,
  input  logic [CW-1:0]  wid_op,
  input  logic [DTW-1:0] dt_val,
  output logic           out_a,
  output logic           out_b
);
  logic           a_on, b_req, b_req_q;
  logic [DTW-1:0] dt_q, dt_nxt;

  assign a_on  = run && (tc < wid_op) && !edge_hit;
  assign b_req = run && !a_on;

  always_comb begin
    if (!dt_en || !b_req)  dt_nxt = '0;
    else if (!b_req_q)     dt_nxt = dt_val;
    else if (dt_q != '0)   dt_nxt = dt_q - DTW'(1);
    else                   dt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_a   <= 1'b0;
      out_b   <= 1'b0;
      dt_q    <= '0;
      b_req_q <= 1'b0;
    end else begin
      out_a   <= a_on ^ pol_a;
      out_b   <= (b_req && (dt_nxt == '0)) ^ pol_b;
      dt_q    <= dt_nxt;
      b_req_q <= b_req;
    end
  end
endmodule

// File: rtl/mcpwm_chan.sv
module mcpwm_chan
  import mcpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned DT_W  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             out_a,
  output logic             out_b
);
  ctl_flags_t       flags;
  logic [CNT_W-1:0] per_op, wid_op, tc;
  logic [DT_W-1:0]  dt_val;
  logic             cnt_down, edge_hit, bound;
  logic             run_w, center_w, dten_w, hold_w, pola_w, polb_w;

  assign run_w    = flags.run;
  assign center_w = flags.center;
  assign dten_w   = flags.dt_en;
  assign hold_w   = flags.hold;
  assign pola_w   = flags.pol_a;
  assign polb_w   = flags.pol_b;

  mcpwm_regs #(.CW(CNT_W), .DTW(DT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .bound(bound), .tc(tc), .per_op(per_op), .wid_op(wid_op),
    .flags(flags), .dt_val(dt_val), .rd_data(rd_data)
  );

  mcpwm_timer #(.CW(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .run(run_w), .center(center_w), .per_op(per_op),
    .tc(tc), .cnt_down(cnt_down), .edge_hit(edge_hit), .bound(bound)
  );

  mcpwm_outgen #(.CW(CNT_W), .DTW(DT_W)) u_out (
    .clk(clk), .rst(rst), .run(run_w), .dt_en(dten_w), .pol_a(pola_w),
    .pol_b(polb_w), .edge_hit(edge_hit), .tc(tc), .wid_op(wid_op),
    .dt_val(dt_val), .out_a(out_a), .out_b(out_b)
  );
endmodule

// File: rtl/mcpwm_chan_chk.sv
module mcpwm_chan_chk #(
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          center,
  input logic          dt_en,
  input logic          hold,
  input logic          pol_a,
  input logic          pol_b,
  input logic          cnt_down,
  input logic [CW-1:0] tc,
  input logic [CW-1:0] per_op,
  input logic [CW-1:0] wid_op,
  input logic          out_a,
  input logic          out_b
);
  assert_stop_clear_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (tc == '0));

  assert_edge_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !center && tc >= per_op) |=> (tc == '0));

  assert_edge_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !center && tc < per_op) |=> (tc == $past(tc) + CW'(1)));

  assert_center_bottom_R3: assert property (@(posedge clk) disable iff (rst)
    (run && center && cnt_down && tc == '0) |=> (tc == CW'(1) && !cnt_down));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (run && hold) |=> ($stable(per_op) && $stable(wid_op)));

  assert_hit_swap_R6: assert property (@(posedge clk) disable iff (rst)
    (run && !center && !dt_en && tc >= per_op) |=>
      ((out_b != $past(pol_b)) && (out_a == $past(pol_a))));
endmodule

bind mcpwm_chan mcpwm_chan_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run_w), .center(center_w), .dt_en(dten_w),
  .hold(hold_w), .pol_a(pola_w), .pol_b(polb_w), .cnt_down(cnt_down),
  .tc(tc), .per_op(per_op), .wid_op(wid_op), .out_a(out_a), .out_b(out_b)
);

// File: tb/sim_mcpwm_chan.sv
`timescale 1ns/1ps
module sim_mcpwm_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        out_a, out_b;

  int checks = 0;
  int errors = 0;
  bit checking = 0;
  bit auto_rd = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  mcpwm_chan u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .out_a(out_a), .out_b(out_b)
  );

  // Behavioural reference
  logic [31:0] m_tc, m_lw, m_lo, m_mw, m_mo, m_ctl, m_rd;
  bit m_down, m_breq, m_a, m_b;
  int m_dt;
  bit r_run, r_cen, r_dte, r_hold, r_pa, r_pb, r_hit, r_aon, r_breq, r_bnd;
  int r_dtv, r_dtn;

  always @(posedge clk) begin
    if (rst) begin
      m_tc = 0; m_down = 0; m_lw = 32'hFFFF_FFFF; m_lo = 32'hFFFF_FFFF;
      m_mw = 0; m_mo = 0; m_ctl = 0; m_dt = 0; m_breq = 0;
      m_a = 0; m_b = 0; m_rd = 0;
    end else begin
      r_run = m_ctl[0]; r_cen = m_ctl[1]; r_dte = m_ctl[2];
      r_hold = m_ctl[3]; r_pa = m_ctl[4]; r_pb = m_ctl[5];
      r_dtv = int'(m_ctl[25:16]);
      r_hit  = r_run && !r_cen && (m_tc >= m_lo);
      r_aon  = r_run && (m_tc < m_mo) && !r_hit;
      r_breq = r_run && !r_aon;
      if (!r_dte || !r_breq) r_dtn = 0;
      else if (!m_breq) r_dtn = r_dtv;
      else if (m_dt > 0) r_dtn = m_dt - 1;
      else r_dtn = 0;
      m_a = r_aon ^ r_pa;
      m_b = (r_breq && r_dtn == 0) ^ r_pb;
      m_dt = r_dtn;
      m_breq = r_breq;
      case (rd_sel)
        2'd0: m_rd = m_lo;
        2'd1: m_rd = m_mo;
        2'd2: m_rd = m_ctl;
        default: m_rd = m_tc;
      endcase
      r_bnd = 0;
      if (!r_run) begin m_tc = 0; m_down = 0; end
      else if (!r_cen) begin r_bnd = r_hit; m_tc = r_hit ? 32'd0 : m_tc + 1; end
      else if (!m_down) begin
        if (m_tc >= m_lo) begin m_down = 1; m_tc = (m_tc == 0) ? 32'd0 : m_tc - 1; end
        else m_tc = m_tc + 1;
      end else if (m_tc == 0) begin m_down = 0; m_tc = 1; r_bnd = 1; end
      else m_tc = m_tc - 1;
      if (!r_run || (r_bnd && !r_hold)) begin m_lo = m_lw; m_mo = m_mw; end
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin m_lw = wr_data; if (!r_run) m_lo = wr_data; end
          2'd1: begin m_mw = wr_data; if (!r_run) m_mo = wr_data; end
          2'd2: m_ctl = wr_data & 32'h03FF_003F;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !rst) begin
      chk({31'd0, out_a}, {31'd0, m_a}, {phase, " out_a R5"});
      chk({31'd0, out_b}, {31'd0, m_b}, {phase, " out_b R6"});
      chk(rd_data, m_rd, {phase, " readback R10"});
    end
    if (auto_rd) rd_sel <= rd_sel + 2'd1;
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en <= 1'b1; wr_sel <= s; wr_data <= d;
    @(negedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [31:0] RUN = 32'h1, CEN = 32'h2, DTE = 32'h4, HOLD = 32'h8;
  localparam logic [31:0] PA = 32'h10, PB = 32'h20;

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst <= 1'b0;
    idle(1);
    // R1 reset state
    rd_sel <= 2'd0; idle(1);
    chk(rd_data, 32'hFFFF_FFFF, "R1 period reset");
    rd_sel <= 2'd1; idle(1);
    chk(rd_data, 32'd0, "R1 width reset");
    rd_sel <= 2'd3; idle(1);
    chk(rd_data, 32'd0, "R1 counter reset");
    chk({31'd0, out_a}, 32'd0, "R1 out_a");
    chk({31'd0, out_b}, 32'd0, "R1 out_b");
    checking = 1; auto_rd = 1;

    phase = "R4 R10"; wr(2'd0, 32'd9); wr(2'd1, 32'd4); wr(2'd3, 32'd5); idle(4);
    phase = "R2 R5 R6 R12"; wr(2'd2, RUN); idle(30);
    phase = "R7"; wr(2'd2, RUN | DTE | (32'd3 << 16)); idle(30);
    phase = "R7 cancel"; wr(2'd2, RUN | DTE | (32'd8 << 16)); idle(25);
    phase = "R8"; wr(2'd2, RUN); wr(2'd0, 32'd5); wr(2'd1, 32'd2); idle(25);
    phase = "R5 wide"; wr(2'd0, 32'd3); wr(2'd1, 32'd10); idle(20);
    phase = "R9"; wr(2'd2, RUN | HOLD); wr(2'd0, 32'd12); wr(2'd1, 32'd7); idle(25);
    wr(2'd2, RUN); idle(30);
    phase = "R9 stop"; wr(2'd2, RUN | HOLD); wr(2'd0, 32'd7); wr(2'd1, 32'd3); idle(5);
    wr(2'd2, 32'd0); idle(3); wr(2'd2, RUN); idle(12);
    phase = "R3"; wr(2'd2, RUN | CEN); idle(40); wr(2'd0, 32'd4); wr(2'd1, 32'd1); idle(30);
    phase = "R3 R7"; wr(2'd2, RUN | CEN | DTE | (32'd2 << 16)); idle(30);
    phase = "R2 mode switch"; wr(2'd2, RUN); idle(15);
    phase = "R11"; wr(2'd2, RUN | PA | PB | DTE | (32'd1 << 16)); idle(30);
    wr(2'd2, PA | PB); idle(5);
    phase = "R4 stopped writes"; wr(2'd0, 32'd2); wr(2'd1, 32'd1); idle(8);
    phase = "R12 control readback"; wr(2'd2, 32'hFFFF_FFFF); idle(12);
    wr(2'd2, 32'd0); idle(4);

    checking = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule